// File: doc/BRIEF.md
# Bit-Reversed Vector Load Address Generator

This block produces the sequence of effective addresses for a vector load whose elements are fetched in bit-reversed order, which is the data reordering step of a radix-2 FFT. A single start pulse captures a base value, a flag saying the base register selector is zero, a signed 16-bit displacement, an element size, a power-of-two vector length and a 3-bit shift. The block then offers one element per handshake.

Each offered element carries three things: the linear destination element number, the bit-reversed index, and the 64-bit effective address. The address is the base plus an offset. The offset is the sign-extended displacement, times the element size, times the bit-reversed index, shifted left by the programmed amount. A one-cycle done pulse follows the last accepted element. A vector length that is not a power of two raises a one-cycle error and produces no elements. Memory access and register writeback belong to the surrounding pipeline.

Top module: `bitrev_agu`

## Requirements
- R1: For element i, addr_o equals base + ((sext64(disp_i) * esize * rev(i)) << shift_i), computed modulo 2^64.
- R2: When base_zero_i is 1 at start, the base term is zero whatever base_i holds.
- R3: disp_i is a two's-complement 16-bit value, sign-extended to 64 bits before it is multiplied.
- R4: rev_o is the element number reversed over log2(VL) bits. For VL=4 the order is 0,2,1,3. For VL=1 it is always 0.
- R5: esize_dw_i=0 selects 4-byte elements and esize_dw_i=1 selects 8-byte elements.
- R6: Every shift_i value from 0 to 7 shifts the scaled offset left by that many bits.
- R7: valid_o rises in the cycle after an accepted start. Exactly VL elements are offered, with elem_o running 0 to VL-1 in ascending order.
- R8: While ready_i is low, valid_o stays high and elem_o, rev_o and addr_o hold their values.
- R9: done_o is high for exactly one cycle, the cycle after the handshake of the last element.
- R10: A start with vl_i that is 0, above 64, or not a power of two raises err_o for one cycle in the next cycle, and no element is offered.
- R11: A start pulse while a sequence is running is ignored, and the running sequence keeps its captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures operands when idle |
| base_i | input | 64 | Base register value |
| base_zero_i | input | 1 | Base register selector is zero; base term forced to 0 |
| disp_i | input | 16 | Signed displacement |
| esize_dw_i | input | 1 | Element size: 0 = 4 bytes, 1 = 8 bytes |
| vl_i | input | 7 | Vector length, power of two from 1 to 64 |
| shift_i | input | 3 | Left shift applied to the scaled offset |
| valid_o | output | 1 | An element is offered |
| ready_i | input | 1 | Consumer accepts the offered element |
| elem_o | output | 6 | Linear destination element number |
| rev_o | output | 6 | Bit-reversed element index |
| addr_o | output | 64 | Effective address |
| done_o | output | 1 | One-cycle pulse after the last handshake |
| err_o | output | 1 | One-cycle pulse for an invalid vector length |

## Verification
The element outputs come from one stage of registers. The first element is therefore due in the cycle after the start edge, and each later element is due in the cycle after the edge at which valid_o and ready_i were both high. done_o and err_o are also registered, so each is due one cycle after the edge that causes it. The bench drives and samples on the falling edge. Each falling-edge sample sees exactly the state that the rising edge before it produced, and the expected element number advances only when that rising edge completed a handshake.

// File: rtl/bitrev_agu_pkg.sv
package bitrev_agu_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic logic is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/bitrev_seq.sv
module bitrev_seq
  import bitrev_agu_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = IDX_W + 1,
  localparam int LG_W  = $clog2(VL_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             ready_i,
  output logic             accept_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LG_W-1:0]  lg_o,
  output logic             last_o,
  output logic             done_o,
  output logic             err_o
);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, vlm1_q;
  logic [LG_W-1:0]  lg_q, lg_d;
  logic             done_q, err_q, vl_ok;

  assign vl_ok = is_pow2(32'(vl_i)) && (vl_i <= VL_W'(MAX_VL));

  always_comb begin
    lg_d = '0;
    for (int k = 0; k < VL_W; k++)
      if (vl_i[k]) lg_d = LG_W'(k);
  end

  assign accept_o = (state_q == SEQ_IDLE) && start_i && vl_ok;
  assign valid_o  = (state_q == SEQ_RUN);
  assign last_o   = (idx_q == vlm1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      vlm1_q  <= '0;
      lg_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            if (vl_ok) begin
              state_q <= SEQ_RUN;
              idx_q   <= '0;
              vlm1_q  <= IDX_W'(vl_i - 1'b1);
              lg_q    <= lg_d;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        SEQ_RUN: begin
          // start_i ignored here
          if (ready_i) begin
            if (last_o) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign lg_o   = lg_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  assert_done_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> done_o && !valid_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_elem_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_o |=> valid_o && (idx_o == $past(idx_o) + 1'b1));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(idx_o));
  assert_err_no_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);

endmodule

// File: rtl/bitrev_index.sv
module bitrev_index #(
  parameter int IDX_W = 6,
  localparam int LG_W = $clog2(IDX_W + 1)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LG_W-1:0]  lg_i,
  output logic [IDX_W-1:0] rev_o
);

  logic [IDX_W-1:0] full_rev;

  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign full_rev[b] = idx_i[IDX_W-1-b];
  end

  // reversal over lg_i bits = full reversal moved down by the unused width
  assign rev_o = full_rev >> (LG_W'(IDX_W) - lg_i);

endmodule

// File: rtl/bitrev_addr.sv
module bitrev_addr #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 6,
  parameter int SH_W   = 3,
  localparam int AMT_W = SH_W + 1
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              esize_dw_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [IDX_W-1:0]  rev_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] disp_ext, scaled, offs, base_eff;
  logic [AMT_W-1:0]  amt;

  assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign scaled   = disp_ext * ADDR_W'(rev_i);
  // element size folded into the shift: 4 B -> +2, 8 B -> +3
  assign amt      = {1'b0, shift_i} + (esize_dw_i ? AMT_W'(3) : AMT_W'(2));
  assign offs     = scaled << amt;
  assign base_eff = base_zero_i ? '0 : base_i;
  assign addr_o   = base_eff + offs;

endmodule

// File: rtl/bitrev_agu.sv
module bitrev_agu
  import bitrev_agu_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int SH_W   = 3,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = IDX_W + 1,
  localparam int LG_W  = $clog2(VL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              esize_dw_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [IDX_W-1:0]  elem_o,
  output logic [IDX_W-1:0]  rev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              err_o
);

  logic              accept, last;
  logic [IDX_W-1:0]  idx, rev;
  logic [LG_W-1:0]   lg;
  logic [ADDR_W-1:0] base_q;
  logic              bz_q, dw_q;
  logic [DISP_W-1:0] disp_q;
  logic [SH_W-1:0]   sh_q;

  bitrev_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .ready_i  (ready_i),
    .accept_o (accept),
    .valid_o  (valid_o),
    .idx_o    (idx),
    .lg_o     (lg),
    .last_o   (last),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      bz_q   <= 1'b0;
      disp_q <= '0;
      dw_q   <= 1'b0;
      sh_q   <= '0;
    end else if (accept) begin
      base_q <= base_i;
      bz_q   <= base_zero_i;
      disp_q <= disp_i;
      dw_q   <= esize_dw_i;
      sh_q   <= shift_i;
    end
  end

  bitrev_index #(.IDX_W(IDX_W)) u_index (
    .idx_i (idx),
    .lg_i  (lg),
    .rev_o (rev)
  );

  bitrev_addr #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .IDX_W  (IDX_W),
    .SH_W   (SH_W)
  ) u_addr (
    .base_i      (base_q),
    .base_zero_i (bz_q),
    .disp_i      (disp_q),
    .esize_dw_i  (dw_q),
    .shift_i     (sh_q),
    .rev_i       (rev),
    .addr_o      (addr_o)
  );

  assign elem_o = idx;
  assign rev_o  = rev;

  assert_rev_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((rev_o >> lg) == '0));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> $stable(addr_o) && $stable(rev_o));
  assert_cfg_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && start_i |=> $stable(base_q) && $stable(disp_q) && $stable(sh_q));

endmodule

// File: tb/sim_bitrev_agu.sv
module sim_bitrev_agu;

  localparam int PERIOD = 10;

  typedef struct packed {
    logic [63:0] base;
    logic        bz;
    logic [15:0] disp;
    logic        dw;
    logic [6:0]  vl;
    logic [2:0]  sh;
  } cfg_t;

  localparam int NV = 6;
  localparam cfg_t VEC [NV] = '{
    '{64'h10,                  1'b0, 16'd8,      1'b1, 7'd4,  3'd0}, // R4 R5 dw
    '{64'h1000,                1'b1, 16'd4,      1'b0, 7'd8,  3'd0}, // R2 base zero
    '{64'h100,                 1'b0, 16'hfffe,   1'b1, 7'd8,  3'd2}, // R3 negative
    '{64'hffff_ffff_ffff_fff0, 1'b0, 16'd1,      1'b0, 7'd64, 3'd7}, // R6 wrap
    '{64'h2000,                1'b0, 16'd100,    1'b1, 7'd1,  3'd3}, // R4 VL=1
    '{64'h40,                  1'b0, 16'd3,      1'b1, 7'd2,  3'd1}  // R6
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, base_zero_i = 1'b0, esize_dw_i = 1'b0, ready_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [6:0]  vl_i = '0;
  logic [2:0]  shift_i = '0;
  logic        valid_o, done_o, err_o;
  logic [5:0]  elem_o, rev_o;
  logic [63:0] addr_o;

  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bitrev_agu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .base_zero_i(base_zero_i), .disp_i(disp_i), .esize_dw_i(esize_dw_i),
    .vl_i(vl_i), .shift_i(shift_i), .valid_o(valid_o), .ready_i(ready_i),
    .elem_o(elem_o), .rev_o(rev_o), .addr_o(addr_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_rev(input cfg_t c, input int i);
    int lg = 0, r = 0;
    while ((1 << lg) < int'(c.vl)) lg++;
    for (int b = 0; b < lg; b++)
      if (i[b]) r |= 1 << (lg - 1 - b);
    return r;
  endfunction

  function automatic logic [63:0] exp_addr(input cfg_t c, input int i);
    logic [63:0] d, o, bs;
    d  = {{48{c.disp[15]}}, c.disp};
    o  = d * 64'(exp_rev(c, i)) * (c.dw ? 64'd8 : 64'd4);
    o  = o << c.sh;
    bs = c.bz ? 64'd0 : c.base;
    return bs + o;
  endfunction

  task automatic drive_cfg(input cfg_t c);
    base_i = c.base; base_zero_i = c.bz; disp_i = c.disp;
    esize_dw_i = c.dw; vl_i = c.vl; shift_i = c.sh;
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0: return "R1 R5";
      1: return "R1 R2";
      2: return "R1 R3";
      3: return "R1 R6";
      4: return "R1 R4";
      default: return "R1 R6";
    endcase
  endfunction

  // one sequence; all sampling and driving at the falling edge
  task automatic run_seq(input cfg_t c, input string tag, input bit stall);
    drive_cfg(c);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ready_i = 1'b1;
    for (int i = 0; i < int'(c.vl); i++) begin
      chk("R7 valid", 64'(valid_o), 64'd1);
      chk("R7 elem", 64'(elem_o), 64'(i));
      chk("R4 rev", 64'(rev_o), 64'(exp_rev(c, i)));
      chk({tag, " addr"}, addr_o, exp_addr(c, i));
      if (stall && i == 1) begin
        ready_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 valid held", 64'(valid_o), 64'd1);
        chk("R8 addr held", addr_o, exp_addr(c, i));
        chk("R8 elem held", 64'(elem_o), 64'(i));
        ready_i = 1'b1;
      end
      @(negedge clk);
    end
    chk("R9 done", 64'(done_o), 64'd1);
    chk("R7 no extra element", 64'(valid_o), 64'd0);
    ready_i = 1'b0;
    @(negedge clk);
    chk("R9 done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic bad_vl(input logic [6:0] v);
    cfg_t c;
    c = VEC[0];
    c.vl = v;
    drive_cfg(c);
    start_i = 1'b1;
    ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 err", 64'(err_o), 64'd1);
    chk("R10 no valid", 64'(valid_o), 64'd0);
    @(negedge clk);
    chk("R10 err one cycle", 64'(err_o), 64'd0);
    chk("R10 still no valid", 64'(valid_o), 64'd0);
    ready_i = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_t a, b;
    repeat (3) @(negedge clk);
    chk("reset valid", 64'(valid_o), 64'd0);
    chk("reset done", 64'(done_o), 64'd0);
    chk("reset err", 64'(err_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_seq(VEC[k], tag_of(k), k == 2);

    // R10: zero, non-power-of-two and oversized lengths
    bad_vl(7'd0);
    bad_vl(7'd6);
    bad_vl(7'd65);

    // R11: second start during a run must not disturb the running sequence
    a = VEC[0];
    b = VEC[2];
    drive_cfg(a);
    start_i = 1'b1;
    @(negedge clk);
    drive_cfg(b);
    ready_i = 1'b0;
    chk("R11 elem0", 64'(elem_o), 64'd0);
    @(negedge clk);
    start_i = 1'b0;
    ready_i = 1'b1;
    for (int i = 0; i < int'(a.vl); i++) begin
      chk("R11 addr", addr_o, exp_addr(a, i));
      chk("R11 elem", 64'(elem_o), 64'(i));
      @(negedge clk);
    end
    chk("R11 done", 64'(done_o), 64'd1);
    ready_i = 1'b0;
    @(negedge clk);
    chk("R11 idle after", 64'(valid_o), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule